// File: doc/BRIEF.md
# I2C Dual-Address Slave Byte Engine

This block is the byte-level slave engine of a two-wire serial interface. It works from SCL and SDA levels that have already been filtered, and from one-cycle START and STOP strobes that a separate bus monitor supplies. After each START it shifts in the first byte and compares the upper seven bits with two own addresses that are programmed independently. If either address matches, the engine acknowledges the byte and records which address was hit. It then uses the read/write bit to choose between receiving and transmitting.

In receive mode each completed byte goes from the shift register into a data register. That register is offered to the core through a valid/ready pair. In transmit mode the core loads a one-byte holding register through a second valid/ready pair, and the engine shifts that byte onto the bus MSB first. The engine never drives SDA high. Its single output `sdaLow` asks the pad to pull the open-drain line low, so a master can share the same bus.

Top module: `i2c_dual_addr_slave`

## Requirements
- R1: While reset is held and right after it, `sdaLow`, `rxValid` and `addrMatched` are 0 and `txReady` is 1.
- R2: The first byte after a START is shifted in MSB first on SCL rising edges. Its bits [7:1] are compared with `ownAddrA` and `ownAddrB`. If either matches, `sdaLow` is 1 for the whole high phase of the ninth SCL clock and `addrMatched` becomes 1.
- R3: `hitSel` reports the address that matched: 0 for `ownAddrA` and 1 for `ownAddrB`. When both addresses are equal, `hitSel` is 0.
- R4: After an address byte that matches neither address, SDA stays released and `rxValid` stays 0 for any later bytes, until the next START.
- R5: When bit 0 of the address byte is 0, each later byte is received MSB first into `rxData`. The engine raises `rxValid` and acknowledges the byte on its ninth clock.
- R6: If `rxValid` is still 1 and `rxReady` is 0 when a received byte completes, the engine does not acknowledge that byte, and `rxData` keeps the older byte.
- R7: When `rxValid` and `rxReady` are both 1 in a cycle, `rxValid` falls in the next cycle.
- R8: When bit 0 of the address byte is 1, the engine transmits. Each byte comes from the holding register, which is filled when `txValid` and `txReady` are both 1. Bits are sent MSB first, and `sdaLow` changes only after an SCL falling edge, so SDA is stable while SCL is high. If the holding register is empty when a byte begins, the engine sends 0xFF.
- R9: In transmit mode, an acknowledge from the master (SDA low on the ninth clock) starts the next byte. A non-acknowledge releases SDA until the next START.
- R10: A START strobe at any point, including in the middle of a byte, clears the bit counter and returns the engine to address reception with SDA released.
- R11: A STOP strobe releases SDA and clears `addrMatched`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Filtered SCL level |
| sdaIn | input | 1 | Filtered SDA level |
| startStb | input | 1 | One-cycle strobe for START or repeated START |
| stopStb | input | 1 | One-cycle strobe for STOP |
| ownAddrA | input | 7 | First own address |
| ownAddrB | input | 7 | Second own address |
| sdaLow | output | 1 | 1 pulls SDA low |
| addrMatched | output | 1 | The current transfer addressed this slave |
| hitSel | output | 1 | Which address matched (0 = A, 1 = B) |
| slaveTx | output | 1 | The engine is in transmit mode |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | `rxData` holds an unconsumed byte |
| rxReady | input | 1 | The core takes `rxData` |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | `txData` is offered |
| txReady | output | 1 | The holding register is empty |

## Verification
The bench builds the engine with the default byte width of 8, which gives 7-bit addresses. The own addresses are 0x2A and 0x55. With this address space the bench can sweep all 128 addresses in write direction and predict arithmetically the acknowledge, the hit indication and whether later bytes are ignored. Data patterns come from simple arithmetic sequences. With these patterns the bench can compare receive, transmit with holding-register refill, backpressure, and a START in the middle of a byte against values it computes itself.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    MIdle,
    MAddr,
    MAddrAck,
    MRx,
    MRxAck,
    MTx,
    MTxAck
  } engMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic captureRx;
  } dpStrobe_t;

endpackage

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - 1,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] ownAddrA,
  input  logic [ADDR_W-1:0] ownAddrB,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  input  logic              rxReady,
  output logic              sclRise,
  output logic              sclFall,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              matchA,
  output logic              matchB,
  output logic              rwBit,
  output logic              shiftNextBit,
  output logic              nextTxMsb,
  output logic              rxFree,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              txReady
);

  logic              sclPrev;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] txHold;
  logic              txFull;
  logic [DATA_W-1:0] txByte;

  // SCL edge detection
  always_ff @(posedge clk) begin
    if (!rstN) sclPrev <= 1'b1;
    else       sclPrev <= sclIn;
  end

  assign sclRise = sclIn & ~sclPrev;
  assign sclFall = ~sclIn & sclPrev;

  // bit counter
  always_ff @(posedge clk) begin
    if (!rstN)            bitCnt <= '0;
    else if (strb.clrCnt) bitCnt <= '0;
    else if (strb.incCnt) bitCnt <= bitCnt + CNT_W'(1);
  end

  // transmit holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold <= '0;
      txFull <= 1'b0;
    end else if (txValid && !txFull) begin
      txHold <= txData;
      txFull <= 1'b1;
    end else if (strb.loadTx) begin
      txFull <= 1'b0;
    end
  end

  assign txReady = ~txFull;
  assign txByte  = txFull ? txHold : '1;

  // shift register, MSB first in both directions
  always_ff @(posedge clk) begin
    if (!rstN)               shiftReg <= '0;
    else if (strb.loadTx)    shiftReg <= txByte;
    else if (strb.shiftIn)   shiftReg <= {shiftReg[DATA_W-2:0], sdaIn};
    else if (strb.shiftOut)  shiftReg <= {shiftReg[DATA_W-2:0], 1'b1};
  end

  assign matchA       = (shiftReg[DATA_W-1:1] == ownAddrA);
  assign matchB       = (shiftReg[DATA_W-1:1] == ownAddrB);
  assign rwBit        = shiftReg[0];
  assign shiftNextBit = shiftReg[DATA_W-2];
  assign nextTxMsb    = txByte[DATA_W-1];

  // receive data register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData  <= '0;
      rxValid <= 1'b0;
    end else if (strb.captureRx) begin
      rxData  <= shiftReg;
      rxValid <= 1'b1;
    end else if (rxReady) begin
      rxValid <= 1'b0;
    end
  end

  assign rxFree = ~rxValid | rxReady;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(DATA_W));

  // R6
  rx_no_overwrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureRx |-> (!rxValid || rxReady));

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !strb.captureRx) |=> (rxValid && $stable(rxData)));

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txReady && !strb.loadTx) |=> (!txReady && $stable(txHold)));

endmodule

// File: rtl/i2cs_control.sv
module i2cs_control
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic             stopStb,
  input  logic             sdaIn,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             matchA,
  input  logic             matchB,
  input  logic             rwBit,
  input  logic             shiftNextBit,
  input  logic             nextTxMsb,
  input  logic             rxFree,
  output dpStrobe_t        strb,
  output logic             sdaLow,
  output logic             addrMatched,
  output logic             hitSel,
  output logic             slaveTx
);

  localparam logic [CNT_W-1:0] LastCnt = CNT_W'(DATA_W);

  engMode_e mode, modeN;
  logic     sdaN, matchedN, hitN, txN, masterAck, ackN;
  logic     byteDone;

  assign byteDone = (bitCnt == LastCnt);

  always_comb begin
    strb     = '0;
    modeN    = mode;
    sdaN     = sdaLow;
    matchedN = addrMatched;
    hitN     = hitSel;
    txN      = slaveTx;
    ackN     = masterAck;
    if (startStb) begin
      modeN       = MAddr;
      sdaN        = 1'b0;
      matchedN    = 1'b0;
      txN         = 1'b0;
      strb.clrCnt = 1'b1;
    end else if (stopStb) begin
      modeN       = MIdle;
      sdaN        = 1'b0;
      matchedN    = 1'b0;
      txN         = 1'b0;
      strb.clrCnt = 1'b1;
    end else begin
      unique case (mode)
        MAddr, MRx: begin
          if (sclRise && !byteDone) begin
            strb.shiftIn = 1'b1;
            strb.incCnt  = 1'b1;
          end else if (sclFall && byteDone) begin
            if (mode == MAddr) begin
              if (matchA || matchB) begin
                sdaN     = 1'b1;
                matchedN = 1'b1;
                hitN     = ~matchA;
                txN      = rwBit;
                modeN    = MAddrAck;
              end else begin
                modeN = MIdle;
              end
            end else begin
              modeN = MRxAck;
              if (rxFree) begin
                strb.captureRx = 1'b1;
                sdaN           = 1'b1;
              end
            end
          end
        end
        MAddrAck: begin
          if (sclFall) begin
            strb.clrCnt = 1'b1;
            if (slaveTx) begin
              strb.loadTx = 1'b1;
              sdaN        = ~nextTxMsb;
              modeN       = MTx;
            end else begin
              sdaN  = 1'b0;
              modeN = MRx;
            end
          end
        end
        MRxAck: begin
          if (sclFall) begin
            sdaN        = 1'b0;
            strb.clrCnt = 1'b1;
            modeN       = MRx;
          end
        end
        MTx: begin
          if (sclRise && !byteDone) begin
            strb.incCnt = 1'b1;
          end else if (sclFall) begin
            if (byteDone) begin
              sdaN  = 1'b0;
              modeN = MTxAck;
            end else if (bitCnt != '0) begin
              strb.shiftOut = 1'b1;
              sdaN          = ~shiftNextBit;
            end
          end
        end
        MTxAck: begin
          if (sclRise) begin
            ackN = ~sdaIn;
          end else if (sclFall) begin
            if (masterAck) begin
              strb.loadTx = 1'b1;
              strb.clrCnt = 1'b1;
              sdaN        = ~nextTxMsb;
              modeN       = MTx;
            end else begin
              sdaN  = 1'b0;
              modeN = MIdle;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode        <= MIdle;
      sdaLow      <= 1'b0;
      addrMatched <= 1'b0;
      hitSel      <= 1'b0;
      slaveTx     <= 1'b0;
      masterAck   <= 1'b0;
    end else begin
      mode        <= modeN;
      sdaLow      <= sdaN;
      addrMatched <= matchedN;
      hitSel      <= hitN;
      slaveTx     <= txN;
      masterAck   <= ackN;
    end
  end

  // R10
  start_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> (bitCnt == '0 && !sdaLow && !addrMatched));

  // R4
  nomatch_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrMatched |-> !sdaLow);

  // R8
  sda_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaLow) |-> $past(sclFall || startStb || stopStb));

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb && !startStb) |=> (!sdaLow && !addrMatched));

endmodule

// File: rtl/i2c_dual_addr_slave.sv
module i2c_dual_addr_slave
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              startStb,
  input  logic              stopStb,
  input  logic [ADDR_W-1:0] ownAddrA,
  input  logic [ADDR_W-1:0] ownAddrB,
  output logic              sdaLow,
  output logic              addrMatched,
  output logic              hitSel,
  output logic              slaveTx,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady
);

  localparam int CntW = $clog2(DATA_W + 1);

  dpStrobe_t       strb;
  logic            sclRise, sclFall;
  logic [CntW-1:0] bitCnt;
  logic            matchA, matchB, rwBit, shiftNextBit, nextTxMsb, rxFree;

  i2cs_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CntW)) uDp (
    .clk, .rstN, .sclIn, .sdaIn, .strb, .ownAddrA, .ownAddrB,
    .txData, .txValid, .rxReady, .sclRise, .sclFall, .bitCnt,
    .matchA, .matchB, .rwBit, .shiftNextBit, .nextTxMsb, .rxFree,
    .rxData, .rxValid, .txReady
  );

  i2cs_control #(.DATA_W(DATA_W), .CNT_W(CntW)) uCtl (
    .clk, .rstN, .startStb, .stopStb, .sdaIn, .sclRise, .sclFall,
    .bitCnt, .matchA, .matchB, .rwBit, .shiftNextBit, .nextTxMsb,
    .rxFree, .strb, .sdaLow, .addrMatched, .hitSel, .slaveTx
  );

endmodule

// File: tb/i2c_dual_addr_slave_test.sv
module i2c_dual_addr_slave_test;

  localparam int DW = 8;
  localparam int AW = DW - 1;
  localparam logic [AW-1:0] ADDR_A = 7'h2A;
  localparam logic [AW-1:0] ADDR_B = 7'h55;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN, scl, mSda, startStb, stopStb;
  logic [AW-1:0] addrA, addrB;
  logic          rxReady, txValid;
  logic [DW-1:0] txData;
  logic          sdaLow, addrMatched, hitSel, slaveTx, rxValid, txReady;
  logic [DW-1:0] rxData;
  logic          busSda;

  assign busSda = mSda & ~sdaLow;

  i2c_dual_addr_slave #(.DATA_W(DW)) uut (
    .clk, .rstN, .sclIn(scl), .sdaIn(busSda), .startStb, .stopStb,
    .ownAddrA(addrA), .ownAddrB(addrB), .sdaLow, .addrMatched, .hitSel,
    .slaveTx, .rxData, .rxValid, .rxReady, .txData, .txValid, .txReady
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'hC3 ^ 8'(k * 29);
  endfunction

  // one SCL clock; master offers b, returns the line level seen while SCL high
  task automatic bitOut(input logic b, output logic seen);
    @(negedge clk); scl = 1'b0;
    repeat (2) @(negedge clk);
    mSda = b;
    repeat (2) @(negedge clk);
    scl = 1'b1;
    repeat (2) @(negedge clk);
    seen = busSda;
    repeat (2) @(negedge clk);
    check("R8", "sda stable while scl high", int'(busSda), int'(seen));
  endtask

  task automatic doStart();
    @(negedge clk); mSda = 1'b0; startStb = 1'b1;
    @(negedge clk); startStb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic doStop();
    @(negedge clk); scl = 1'b0;
    repeat (2) @(negedge clk);
    mSda = 1'b0;
    repeat (2) @(negedge clk);
    scl = 1'b1;
    repeat (2) @(negedge clk);
    stopStb = 1'b1; mSda = 1'b1;
    @(negedge clk); stopStb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bitOut(v[i], s);
    bitOut(1'b1, s);
    acked = ~s;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitOut(1'b1, s);
      v[i] = s;
    end
    bitOut(~giveAck, s);
  endtask

  task automatic pushTx(input logic [7:0] v);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txValid = 1'b1; txData = v;
    @(negedge clk); txValid = 1'b0;
    check("R8", "txReady low once holding register is full", int'(txReady), 0);
  endtask

  task automatic consume();
    @(negedge clk); rxReady = 1'b1;
    @(negedge clk); rxReady = 1'b0;
    check("R7", "rxValid cleared after handshake", int'(rxValid), 0);
  endtask

  initial begin
    logic       ack, s, allHigh;
    logic [7:0] v;
    rstN = 1'b0; scl = 1'b1; mSda = 1'b1; startStb = 1'b0; stopStb = 1'b0;
    addrA = ADDR_A; addrB = ADDR_B; rxReady = 1'b0; txValid = 1'b0; txData = '0;
    repeat (4) @(negedge clk);
    check("R1", "sdaLow in reset", int'(sdaLow), 0);
    check("R1", "rxValid in reset", int'(rxValid), 0);
    check("R1", "addrMatched in reset", int'(addrMatched), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "txReady after reset", int'(txReady), 1);

    // full sweep of the address space, write direction
    for (int a = 0; a < 128; a++) begin
      automatic logic hit = (7'(a) == ADDR_A) || (7'(a) == ADDR_B);
      doStart();
      sendByte({7'(a), 1'b0}, ack);
      check("R2", $sformatf("ack for address %0d", a), int'(ack), int'(hit));
      check("R2", $sformatf("addrMatched for address %0d", a), int'(addrMatched), int'(hit));
      if (hit) begin
        check("R3", $sformatf("hitSel for address %0d", a), int'(hitSel), int'(7'(a) == ADDR_B));
      end else begin
        sendByte(8'h96, ack);
        check("R4", "data after foreign address not acked", int'(ack), 0);
        check("R4", "rxValid after foreign address", int'(rxValid), 0);
      end
      doStop();
      check("R11", "sdaLow after stop", int'(sdaLow), 0);
      check("R11", "addrMatched after stop", int'(addrMatched), 0);
    end

    // equal addresses: A wins
    addrB = ADDR_A;
    doStart();
    sendByte({ADDR_A, 1'b0}, ack);
    check("R3", "ack with equal addresses", int'(ack), 1);
    check("R3", "hitSel with equal addresses", int'(hitSel), 0);
    doStop();
    addrB = ADDR_B;

    // receive stream
    doStart();
    sendByte({ADDR_B, 1'b0}, ack);
    check("R5", "address ack for write", int'(ack), 1);
    check("R5", "slaveTx low in write", int'(slaveTx), 0);
    for (int k = 0; k < 16; k++) begin
      automatic logic [7:0] d = 8'(k * 37 + 5);
      sendByte(d, ack);
      check("R5", "data byte acked", int'(ack), 1);
      check("R5", "rxValid after byte", int'(rxValid), 1);
      check("R5", "rxData value", int'(rxData), int'(d));
      consume();
    end

    // backpressure
    sendByte(8'hA5, ack);
    check("R6", "first byte acked", int'(ack), 1);
    sendByte(8'h3C, ack);
    check("R6", "second byte refused", int'(ack), 0);
    check("R6", "older byte kept", int'(rxData), 8'hA5);
    check("R6", "rxValid kept", int'(rxValid), 1);
    consume();
    doStop();

    // transmit stream
    pushTx(pat(0));
    doStart();
    sendByte({ADDR_A, 1'b1}, ack);
    check("R8", "address ack for read", int'(ack), 1);
    check("R8", "slaveTx in read", int'(slaveTx), 1);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) pushTx(pat(k));
      recvByte(k != 7, v);
      check("R8", $sformatf("tx byte %0d", k), int'(v), int'(pat(k)));
    end
    allHigh = 1'b1;
    for (int i = 0; i < 9; i++) begin
      bitOut(1'b1, s);
      allHigh &= s;
    end
    check("R9", "line released after master nack", int'(allHigh), 1);
    doStop();

    // transmit with empty holding register
    doStart();
    sendByte({ADDR_B, 1'b1}, ack);
    check("R9", "read address acked", int'(ack), 1);
    recvByte(1'b0, v);
    check("R8", "empty holding register sends all ones", int'(v), 8'hFF);
    doStop();

    // repeated START in the middle of a write byte
    doStart();
    sendByte({ADDR_A, 1'b0}, ack);
    for (int i = 0; i < 3; i++) bitOut(1'b0, s);
    doStart();
    sendByte({ADDR_B, 1'b0}, ack);
    check("R10", "ack after restart mid byte", int'(ack), 1);
    check("R10", "hitSel after restart", int'(hitSel), 1);
    sendByte(8'h5A, ack);
    check("R10", "byte after restart aligned", int'(rxData), 8'h5A);
    consume();
    doStop();

    // repeated START in the middle of a read byte
    pushTx(8'h81);
    doStart();
    sendByte({ADDR_A, 1'b1}, ack);
    for (int i = 0; i < 4; i++) bitOut(1'b1, s);
    doStart();
    check("R10", "sda released by restart", int'(sdaLow), 0);
    sendByte({ADDR_B, 1'b0}, ack);
    check("R10", "ack after restart in read", int'(ack), 1);
    check("R10", "write mode after restart", int'(slaveTx), 0);
    doStop();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule